// File: doc/BRIEF.md
# Trap Entry Sequencer

This block carries out the state changes a processor makes when it takes a trap. A request arrives with a 9-bit trap type, the composed status word, the current PC and the next PC. The block then raises the trap level by one and stores those four values in a small stack that has one entry per level. It rewrites the processor-state mode bits according to the class of the trap. For window traps it moves the current register-window pointer. Finally it forms the handler address from the trap base register.

The trap level, the window pointer, the processor-state bits and an error flag are held inside the block and appear on its outputs. When the trap level is already exhausted, a request does not enter: the block raises a sticky error flag and leaves the rest of its state as it was. A second register base is used for the handler address while a hypervisor-mode input is high. The stack has a registered read port, so the return path can fetch a saved level.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset the trap level, window pointer, processor-state bits, error flag and done pulse are all zero.
- R2: A request while `trap_level < MAX_TL` is accepted on the clock edge. After that edge `trap_level` is one higher and `entry_done` is high for exactly one cycle.
- R3: State bit 5 (reduced-state) is set when a request is accepted with `trap_level == MAX_TL-1`. Otherwise it keeps its previous value.
- R4: A request while `trap_level >= MAX_TL` sets `error_state`, which stays set until reset. Such a request produces no `entry_done` and leaves the trap level, window pointer and state bits unchanged.
- R5: An accepted trap writes status word, PC, next PC and trap type into the stack entry indexed by the new level modulo `STACK_DEPTH`. The read port returns entry `rd_level` one cycle after `rd_level` is presented.
- R6: After entry the state bits are bit 3 (privileged) = 1, bit 4 (FPU enable) = 1 and exactly one global-select bit set. Bit 1 (MMU globals) is chosen for types 0x008, 0x030, 0x064..0x067, 0x068..0x06B and 0x06C..0x06F. Bit 2 (interrupt globals) is chosen for type 0x060. Bit 0 (alternate globals) is chosen for every other type.
- R7: Type 0x024 (clean window) decrements the window pointer by one, modulo `NWIN`.
- R8: A type with bits 8:6 = 3'b010 (spill) sets the pointer to pointer − `cansave` − 2, modulo `NWIN`. A type with bits 8:6 = 3'b011 (fill) increments the pointer by one, modulo `NWIN`. All other types leave the pointer unchanged.
- R9: With `hyp_mode` low, `vec_pc` = (`trap_base` with bits 14:0 cleared) | (bit 14 if the new level > 1) | (type << 5).
- R10: With `hyp_mode` high, `vec_pc` = (`hyp_base` with bits 13:0 cleared) | (type << 5).
- R11: `vec_npc` equals `vec_pc` + 4, and both are valid while `entry_done` is high.
- R12: A stack read and a push to the same entry in the same cycle return the entry's previous contents. The new contents are returned on the following read. Stack contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Trap request, one per cycle |
| trap_type | input | 9 | Trap type of the request |
| status_word | input | ST_W | Composed status word to save |
| cur_pc | input | PC_W | PC to save |
| cur_npc | input | PC_W | Next PC to save |
| cansave | input | CWP_W | Number of windows that can still be saved |
| trap_base | input | PC_W | Normal trap base address |
| hyp_base | input | PC_W | Hypervisor trap base address |
| hyp_mode | input | 1 | Selects the hypervisor vector form |
| rd_level | input | IDX_W | Stack entry to read |
| rd_status | output | ST_W | Saved status word of the read entry |
| rd_pc | output | PC_W | Saved PC of the read entry |
| rd_npc | output | PC_W | Saved next PC of the read entry |
| rd_tt | output | 9 | Saved trap type of the read entry |
| trap_level | output | TL_W | Current trap level |
| cwp | output | CWP_W | Current window pointer |
| pstate | output | 6 | Processor-state bits |
| error_state | output | 1 | Sticky level-exhausted flag |
| entry_done | output | 1 | One-cycle pulse after an accepted entry |
| vec_pc | output | PC_W | Handler PC |
| vec_npc | output | PC_W | Handler next PC |

## Verification
A push to the trap stack and a read of the same entry can fall into one cycle. The bench provokes this in three steps. It stores a known PC at level one, resets, and then issues a new trap while `rd_level` points at level one. The read in that cycle must return the old PC, and the read in the cycle after must return the new one. A second overlap is an entry that both saturates the level and sets the reduced-state bit. Here the bench drives the level up to the limit and checks the state bits after each entry and after the rejected request that follows.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  localparam int TT_W = 9;
  localparam int PS_W = 6;

  // state bit positions
  localparam int PS_ALT  = 0;
  localparam int PS_MMU  = 1;
  localparam int PS_INTG = 2;
  localparam int PS_PRIV = 3;
  localparam int PS_FPEN = 4;
  localparam int PS_RED  = 5;

  // trap type codes the block decodes
  localparam logic [TT_W-1:0] TT_INST_FAULT = 9'h008;
  localparam logic [TT_W-1:0] TT_CLEAN_WIN  = 9'h024;
  localparam logic [TT_W-1:0] TT_DATA_FAULT = 9'h030;
  localparam logic [TT_W-1:0] TT_VEC_INT    = 9'h060;
  localparam logic [TT_W-1:0] TT_INST_MISS  = 9'h064;
  localparam logic [TT_W-1:0] TT_DATA_MISS  = 9'h068;
  localparam logic [TT_W-1:0] TT_DATA_PROT  = 9'h06C;
  localparam logic [2:0]      GRP_SPILL     = 3'b010;
  localparam logic [2:0]      GRP_FILL      = 3'b011;

  typedef enum logic [1:0] {GSEL_ALT, GSEL_MMU, GSEL_INT} gsel_e;
  typedef enum logic [1:0] {WOP_NONE, WOP_CLEAN, WOP_SPILL, WOP_FILL} wop_e;
endpackage

// File: rtl/trap_class_decode.sv
module trap_class_decode
  import trap_seq_pkg::*;
(
  input  logic [TT_W-1:0] tt,
  output gsel_e           gsel,
  output wop_e            wop
);
  logic is_mmu;

  always_comb begin
    is_mmu = (tt == TT_INST_FAULT) || (tt == TT_DATA_FAULT) ||
             (tt[8:2] == TT_INST_MISS[8:2]) ||
             (tt[8:2] == TT_DATA_MISS[8:2]) ||
             (tt[8:2] == TT_DATA_PROT[8:2]);
    if (tt == TT_VEC_INT)  gsel = GSEL_INT;
    else if (is_mmu)       gsel = GSEL_MMU;
    else                   gsel = GSEL_ALT;

    if (tt == TT_CLEAN_WIN)         wop = WOP_CLEAN;
    else if (tt[8:6] == GRP_SPILL)  wop = WOP_SPILL;
    else if (tt[8:6] == GRP_FILL)   wop = WOP_FILL;
    else                            wop = WOP_NONE;
  end
endmodule

// File: rtl/trap_window_calc.sv
module trap_window_calc
  import trap_seq_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int CWP_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  wop_e             wop,
  input  logic [CWP_W-1:0] cwp_cur,
  input  logic [CWP_W-1:0] cansave,
  output logic [CWP_W-1:0] cwp_next
);
  localparam int EW = CWP_W + 2;
  localparam logic [EW-1:0] NW_E  = EW'(NWIN);
  localparam logic [EW-1:0] NW2_E = EW'(2 * NWIN);
  localparam logic [EW-1:0] ONE_E = EW'(1);
  localparam logic [EW-1:0] TWO_E = EW'(2);

  logic [EW-1:0] ext_cwp, ext_cs, raw, wrapped;

  always_comb begin
    ext_cwp = {2'b00, cwp_cur};
    ext_cs  = {2'b00, cansave};
    unique case (wop)
      WOP_CLEAN: raw = ext_cwp + NW_E - ONE_E;
      WOP_SPILL: raw = ext_cwp + NW2_E - ext_cs - TWO_E;
      WOP_FILL:  raw = ext_cwp + ONE_E;
      default:   raw = ext_cwp;
    endcase
    wrapped  = raw % NW_E;
    cwp_next = wrapped[CWP_W-1:0];
  end
endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
  import trap_seq_pkg::*;
#(
  parameter int PC_W = 64,
  parameter int TL_W = 3
) (
  input  logic [TT_W-1:0] tt,
  input  logic [TL_W-1:0] tl_new,
  input  logic [PC_W-1:0] base,
  input  logic [PC_W-1:0] hbase,
  input  logic            hyp,
  output logic [PC_W-1:0] pc_out,
  output logic [PC_W-1:0] npc_out
);
  localparam logic [PC_W-1:0] NORM_MASK = ~PC_W'(32'h7FFF);
  localparam logic [PC_W-1:0] HYP_MASK  = ~PC_W'(32'h3FFF);
  localparam logic [PC_W-1:0] HI_LVL    = PC_W'(32'h4000);
  localparam logic [PC_W-1:0] STEP      = PC_W'(4);

  logic [PC_W-1:0] off;

  always_comb begin
    off = '0;
    off[TT_W+4:5] = tt;
    if (hyp)
      pc_out = (hbase & HYP_MASK) | off;
    else
      pc_out = (base & NORM_MASK) | ((tl_new > TL_W'(1)) ? HI_LVL : '0) | off;
    npc_out = pc_out + STEP;
  end
endmodule

// File: rtl/trap_stack_mem.sv
module trap_stack_mem #(
  parameter int W     = 64,
  parameter int DEPTH = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // read-first single clock memory, no reset on contents
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int PC_W        = 64,
  parameter int ST_W        = 64,
  parameter int NWIN        = 8,
  parameter int MAX_TL      = 5,
  parameter int STACK_DEPTH = 8,
  parameter int CWP_W       = (NWIN > 1) ? $clog2(NWIN) : 1,
  parameter int TL_W        = $clog2(MAX_TL + 1),
  parameter int IDX_W       = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_req,
  input  logic [TT_W-1:0]   trap_type,
  input  logic [ST_W-1:0]   status_word,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [PC_W-1:0]   cur_npc,
  input  logic [CWP_W-1:0]  cansave,
  input  logic [PC_W-1:0]   trap_base,
  input  logic [PC_W-1:0]   hyp_base,
  input  logic              hyp_mode,
  input  logic [IDX_W-1:0]  rd_level,
  output logic [ST_W-1:0]   rd_status,
  output logic [PC_W-1:0]   rd_pc,
  output logic [PC_W-1:0]   rd_npc,
  output logic [TT_W-1:0]   rd_tt,
  output logic [TL_W-1:0]   trap_level,
  output logic [CWP_W-1:0]  cwp,
  output logic [PS_W-1:0]   pstate,
  output logic              error_state,
  output logic              entry_done,
  output logic [PC_W-1:0]   vec_pc,
  output logic [PC_W-1:0]   vec_npc
);
  localparam int ENT_W = ST_W + 2 * PC_W + TT_W;
  localparam logic [TL_W-1:0] TL_MAX  = TL_W'(MAX_TL);
  localparam logic [TL_W-1:0] TL_LAST = TL_W'(MAX_TL - 1);

  logic [TL_W-1:0]  tl_q, tl_new;
  logic [CWP_W-1:0] cwp_q, cwp_calc;
  logic [PS_W-1:0]  ps_q, ps_new;
  logic             err_q, done_q, at_max, accept;
  logic [PC_W-1:0]  pc_q, npc_q, pc_calc, npc_calc;
  gsel_e            gsel;
  wop_e             wop;
  logic [ENT_W-1:0] wr_ent, rd_ent;
  logic [IDX_W-1:0] wr_idx;

  assign at_max = (tl_q >= TL_MAX);
  assign accept = trap_req && !at_max;
  assign tl_new = tl_q + TL_W'(1);
  assign wr_idx = IDX_W'(tl_new);
  assign wr_ent = {status_word, cur_pc, cur_npc, trap_type};

  trap_class_decode u_dec (
    .tt   (trap_type),
    .gsel (gsel),
    .wop  (wop)
  );

  trap_window_calc #(.NWIN(NWIN), .CWP_W(CWP_W)) u_win (
    .wop      (wop),
    .cwp_cur  (cwp_q),
    .cansave  (cansave),
    .cwp_next (cwp_calc)
  );

  trap_vector_gen #(.PC_W(PC_W), .TL_W(TL_W)) u_vec (
    .tt      (trap_type),
    .tl_new  (tl_new),
    .base    (trap_base),
    .hbase   (hyp_base),
    .hyp     (hyp_mode),
    .pc_out  (pc_calc),
    .npc_out (npc_calc)
  );

  trap_stack_mem #(.W(ENT_W), .DEPTH(STACK_DEPTH), .AW(IDX_W)) u_stk (
    .clk   (clk),
    .we    (accept),
    .waddr (wr_idx),
    .wdata (wr_ent),
    .raddr (rd_level),
    .rdata (rd_ent)
  );

  always_comb begin
    ps_new = '0;
    ps_new[PS_PRIV] = 1'b1;
    ps_new[PS_FPEN] = 1'b1;
    ps_new[PS_RED]  = ps_q[PS_RED] | (tl_q == TL_LAST);
    unique case (gsel)
      GSEL_MMU: ps_new[PS_MMU]  = 1'b1;
      GSEL_INT: ps_new[PS_INTG] = 1'b1;
      default:  ps_new[PS_ALT]  = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tl_q   <= '0;
      cwp_q  <= '0;
      ps_q   <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      pc_q   <= '0;
      npc_q  <= '0;
    end else begin
      done_q <= accept;
      if (trap_req && at_max) err_q <= 1'b1;
      if (accept) begin
        tl_q  <= tl_new;
        cwp_q <= cwp_calc;
        ps_q  <= ps_new;
        pc_q  <= pc_calc;
        npc_q <= npc_calc;
      end
    end
  end

  assign {rd_status, rd_pc, rd_npc, rd_tt} = rd_ent;
  assign trap_level  = tl_q;
  assign cwp         = cwp_q;
  assign pstate      = ps_q;
  assign error_state = err_q;
  assign entry_done  = done_q;
  assign vec_pc      = pc_q;
  assign vec_npc     = npc_q;

  // R2: an accepted request steps the level by one
  p_tl_step_r2: assert property (@(posedge clk) disable iff (rst)
    (trap_req && trap_level < TL_MAX) |=> (trap_level == $past(trap_level) + TL_W'(1)));
  // R2: done only follows a request
  p_done_cause_r2: assert property (@(posedge clk) disable iff (rst)
    entry_done |-> $past(trap_req));
  // R3: saturating entry raises reduced-state
  p_red_set_r3: assert property (@(posedge clk) disable iff (rst)
    (trap_req && trap_level == TL_LAST) |=> pstate[PS_RED]);
  // R4: exhausted level rejects entry
  p_no_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (trap_req && trap_level >= TL_MAX) |=> ($stable(trap_level) && $stable(cwp) && !entry_done && error_state));
  // R4: error is sticky
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    error_state |=> error_state);
  // R6: exactly one global set selected after entry
  p_one_gset_r6: assert property (@(posedge clk) disable iff (rst)
    entry_done |-> ($countones(pstate[2:0]) == 1 && pstate[PS_PRIV] && pstate[PS_FPEN]));
  // R11: vector alignment and next PC
  p_vec_align_r11: assert property (@(posedge clk) disable iff (rst)
    entry_done |-> (vec_pc[4:0] == 5'd0 && vec_npc == vec_pc + PC_W'(4)));
endmodule

// File: tb/tb_trap_entry_seq.sv
`timescale 1ns/1ps
module tb_trap_entry_seq;
  localparam int PC_W = 64, ST_W = 64, CWP_W = 3, TL_W = 3, IDX_W = 3;

  logic clk = 1'b0, rst = 1'b1, trap_req = 1'b0, hyp_mode = 1'b0;
  logic [8:0] trap_type = '0;
  logic [ST_W-1:0] status_word = '0;
  logic [PC_W-1:0] cur_pc = '0, cur_npc = '0, trap_base = '0, hyp_base = '0;
  logic [CWP_W-1:0] cansave = '0;
  logic [IDX_W-1:0] rd_level = '0;
  logic [ST_W-1:0] rd_status;
  logic [PC_W-1:0] rd_pc, rd_npc, vec_pc, vec_npc;
  logic [8:0] rd_tt;
  logic [TL_W-1:0] trap_level;
  logic [CWP_W-1:0] cwp;
  logic [5:0] pstate;
  logic error_state, entry_done;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  trap_entry_seq dut (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_type(trap_type),
    .status_word(status_word), .cur_pc(cur_pc), .cur_npc(cur_npc),
    .cansave(cansave), .trap_base(trap_base), .hyp_base(hyp_base),
    .hyp_mode(hyp_mode), .rd_level(rd_level), .rd_status(rd_status),
    .rd_pc(rd_pc), .rd_npc(rd_npc), .rd_tt(rd_tt), .trap_level(trap_level),
    .cwp(cwp), .pstate(pstate), .error_state(error_state),
    .entry_done(entry_done), .vec_pc(vec_pc), .vec_npc(vec_npc));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] norm_vec(input logic [63:0] b, input int lvl, input logic [8:0] t);
    logic [63:0] r;
    r = b & ~64'h7FFF;
    if (lvl > 1) r = r | 64'h4000;
    return r | ({55'd0, t} << 5);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; trap_req = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic issue(input logic [8:0] t, input logic [63:0] pc, input logic [63:0] st);
    @(negedge clk);
    trap_type = t; cur_pc = pc; cur_npc = pc + 64'd4; status_word = st; trap_req = 1'b1;
    @(posedge clk);
    @(negedge clk); trap_req = 1'b0;
  endtask

  task automatic read_lvl(input int lvl);
    @(negedge clk); rd_level = IDX_W'(lvl);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(trap_level == 0 && cwp == 0 && pstate == 0 && !error_state && !entry_done,
        "R1 reset state", {trap_level, cwp, pstate, error_state, entry_done}, 64'd0);
  endtask

  task automatic t_levels();
    do_reset();
    for (int i = 1; i <= 5; i++) begin
      issue(9'h041, 64'h1000 + 64'(i), 64'(i));
      chk(trap_level == TL_W'(i), "R2 level step", 64'(trap_level), 64'(i));
      chk(entry_done, "R2 done pulse", 64'(entry_done), 64'd1);
      chk(pstate[5] == (i == 5), "R3 reduced-state", 64'(pstate[5]), 64'(i == 5));
    end
    @(negedge clk);
    chk(!entry_done, "R2 single pulse", 64'(entry_done), 64'd0);
  endtask

  task automatic t_error();
    issue(9'h041, 64'h2000, 64'd9);
    chk(error_state, "R4 error flag", 64'(error_state), 64'd1);
    chk(!entry_done, "R4 no done", 64'(entry_done), 64'd0);
    chk(trap_level == 5 && pstate == 6'h39, "R4 state kept", {trap_level, pstate}, {3'd5, 6'h39});
    repeat (3) @(negedge clk);
    chk(error_state, "R4 sticky", 64'(error_state), 64'd1);
  endtask

  task automatic t_stack();
    do_reset();
    issue(9'h0AB, 64'hAAAA_0000_0000_1100, 64'hDEAD_BEEF_0000_0001);
    read_lvl(1);
    chk(rd_pc == 64'hAAAA_0000_0000_1100, "R5 saved pc", rd_pc, 64'hAAAA_0000_0000_1100);
    chk(rd_npc == 64'hAAAA_0000_0000_1104, "R5 saved npc", rd_npc, 64'hAAAA_0000_0000_1104);
    chk(rd_tt == 9'h0AB, "R5 saved tt", 64'(rd_tt), 64'h0AB);
    chk(rd_status == 64'hDEAD_BEEF_0000_0001, "R5 saved status", rd_status, 64'hDEAD_BEEF_0000_0001);
  endtask

  task automatic t_collision();
    do_reset();
    @(negedge clk);
    rd_level = 3'd1; trap_type = 9'h041; cur_pc = 64'hBBBB_0000_0000_2200;
    cur_npc = cur_pc + 64'd4; status_word = 64'd7; trap_req = 1'b1;
    @(posedge clk);
    @(negedge clk); trap_req = 1'b0;
    chk(rd_pc == 64'hAAAA_0000_0000_1100, "R12 read-before-write", rd_pc, 64'hAAAA_0000_0000_1100);
    @(posedge clk);
    @(negedge clk);
    chk(rd_pc == 64'hBBBB_0000_0000_2200, "R12 new data next read", rd_pc, 64'hBBBB_0000_0000_2200);
  endtask

  task automatic mode_one(input logic [8:0] t, input logic [5:0] exp);
    do_reset();
    issue(t, 64'h3000, 64'd0);
    chk(pstate == exp, "R6 mode bits", 64'(pstate), 64'(exp));
  endtask

  task automatic t_modes();
    mode_one(9'h008, 6'h1A);
    mode_one(9'h030, 6'h1A);
    mode_one(9'h060, 6'h1C);
    mode_one(9'h065, 6'h1A);
    mode_one(9'h06B, 6'h1A);
    mode_one(9'h06F, 6'h1A);
    mode_one(9'h070, 6'h19);
    mode_one(9'h063, 6'h19);
  endtask

  task automatic t_windows();
    do_reset();
    issue(9'h024, 64'h4000, 64'd0);
    chk(cwp == 3'd7, "R7 clean window wrap", 64'(cwp), 64'd7);
    cansave = 3'd3;
    issue(9'h084, 64'h4000, 64'd0);
    chk(cwp == 3'd2, "R8 spill", 64'(cwp), 64'd2);
    issue(9'h0C8, 64'h4000, 64'd0);
    chk(cwp == 3'd3, "R8 fill", 64'(cwp), 64'd3);
    cansave = 3'd6;
    issue(9'h0BC, 64'h4000, 64'd0);
    chk(cwp == 3'd3, "R8 spill wrap", 64'(cwp), 64'd3);
    issue(9'h041, 64'h4000, 64'd0);
    chk(cwp == 3'd3, "R8 other type keeps pointer", 64'(cwp), 64'd3);
  endtask

  task automatic t_vector();
    do_reset();
    hyp_mode = 1'b0;
    trap_base = 64'hFFFF_0000_1234_FFFF;
    issue(9'h041, 64'h5000, 64'd0);
    chk(vec_pc == norm_vec(trap_base, 1, 9'h041), "R9 vector level 1", vec_pc, norm_vec(trap_base, 1, 9'h041));
    chk(vec_npc == vec_pc + 64'd4, "R11 next pc", vec_npc, vec_pc + 64'd4);
    issue(9'h1FF, 64'h5000, 64'd0);
    chk(vec_pc == norm_vec(trap_base, 2, 9'h1FF), "R9 vector level 2", vec_pc, norm_vec(trap_base, 2, 9'h1FF));
  endtask

  task automatic t_hyper();
    do_reset();
    hyp_mode = 1'b1;
    hyp_base = 64'h0000_0000_9876_FFFF;
    issue(9'h0C0, 64'h6000, 64'd0);
    chk(vec_pc == 64'h9876_D800, "R10 hyper vector", vec_pc, 64'h9876_D800);
    issue(9'h041, 64'h6000, 64'd0);
    chk(vec_pc == 64'h9876_C820, "R10 hyper vector level 2", vec_pc, 64'h9876_C820);
    chk(vec_npc == 64'h9876_C824, "R11 hyper next pc", vec_npc, 64'h9876_C824);
    hyp_mode = 1'b0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_levels();
    t_error();
    t_stack();
    t_collision();
    t_modes();
    t_windows();
    t_vector();
    t_hyper();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule